// File: doc/BRIEF.md
# Serial BCD to Excess-3 Converter

This block turns a decimal digit that arrives one bit per clock, least significant bit first, into its excess-3 form (the digit value plus three). It produces one output bit per input bit, in the same cycle. A seven-state Mealy machine does the add-three. The states track the bit position and the running carry, so the block has no adder and no lookup table.

A producer drives `ser_bit` together with `ser_valid`. A cycle with the strobe low is a bubble: it leaves the machine where it was. The output is a function of the bit present now and the current state, so `e3_bit` holds the answer for input bit k while bit k is on the input.

On the fourth valid bit the block raises a one-cycle completion pulse and returns to its start state by itself, ready for the next digit with no reset. If the finished input code was one of the six non-decimal patterns, a range flag is raised in the same cycle.

Top module: `e3_serial_conv`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the machine goes to its start state. In any cycle where `rst_n` is low, `e3_bit`, `digit_last` and `digit_bad` are 0.
- R2: For the four valid bits of a digit v (0..15), taken in the order bit0, bit1, bit2, bit3, output bit k equals bit k of (v + 3) mod 16. That bit appears in the same cycle as input bit k, before the clock edge that accepts it.
- R3: A cycle with `ser_valid` low changes no state. The outputs are 0 in that cycle, and the digit resumes at the same bit position with the same carry.
- R4: `digit_last` is 1 exactly in the cycle carrying the fourth valid bit of a digit. The next valid bit is treated as bit0 of a new digit, with no reset needed.
- R5: `digit_bad` is 1 only in a `digit_last` cycle, and only when the completed code is greater than 9 (1010 through 1111).
- R6: A reset in the middle of a digit discards the partial digit. The next valid bit after reset is bit0 of a new digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_bit | input | 1 | Serial BCD bit, least significant first |
| ser_valid | input | 1 | High when `ser_bit` carries a digit bit |
| e3_bit | output | 1 | Excess-3 bit for the current input bit (Mealy) |
| digit_last | output | 1 | Pulse on the fourth bit of a digit |
| digit_bad | output | 1 | Completed digit was above 9 (valid with `digit_last`) |

## Verification
The hardest states to reach are those where a bubble arrives while the carry is pending at a given bit position. A reset landing part-way through a digit is just as hard. Such a cycle must freeze the machine and must not disturb the carry or the range memory. The stimulus covers this by sending every digit code back to back, then sending every code again with a bubble inserted after each possible bit position. Resets are also inserted after one, two and three bits. A pseudo-random run of mixed bits and bubbles follows.

// File: rtl/e3_pkg.sv
// Package: shared state encoding and helpers for the serial excess-3 converter.
// Assumes digits are four bits wide and arrive least significant bit first.
package e3_pkg;

    localparam int DIGIT_BITS = 4;
    localparam int POS_W      = $clog2(DIGIT_BITS);
    localparam int ST_W       = 3;

    // Start state plus one state per (bit position, carry) pair after bit0.
    typedef enum logic [ST_W-1:0] {
        ST_IDLE  = 3'd0,
        ST_P1_C0 = 3'd1,
        ST_P1_C1 = 3'd2,
        ST_P2_C0 = 3'd3,
        ST_P2_C1 = 3'd4,
        ST_P3_C0 = 3'd5,
        ST_P3_C1 = 3'd6
    } e3_state_t;

    // Bit position the machine expects next.
    function automatic logic [POS_W-1:0] state_pos(input e3_state_t s);
        case (s)
            ST_P1_C0, ST_P1_C1: state_pos = POS_W'(1);
            ST_P2_C0, ST_P2_C1: state_pos = POS_W'(2);
            ST_P3_C0, ST_P3_C1: state_pos = POS_W'(3);
            default:            state_pos = '0;
        endcase
    endfunction

    // Carry held into the expected bit position.
    function automatic logic state_carry(input e3_state_t s);
        state_carry = (s == ST_P1_C1) || (s == ST_P2_C1) || (s == ST_P3_C1);
    endfunction

endpackage

// File: rtl/e3_next_state.sv
// Next-state logic: advances the bit position and updates the carry of the
// add-three. Assumes the state input is one of the seven legal encodings;
// any other encoding falls back to the start state.
module e3_next_state
    import e3_pkg::*;
(
    input  e3_state_t cur_state,
    input  logic      din,
    input  logic      din_vld,
    output e3_state_t nxt_state
);

    // Transition function; a bubble holds the present state.
    always_comb begin
        nxt_state = cur_state;
        if (din_vld) begin
            case (cur_state)
                // bit0 gets +1: carry out equals the input bit
                ST_IDLE:  nxt_state = din ? ST_P1_C1 : ST_P1_C0;
                // bit1 gets +1 plus carry: carry out = din | carry
                ST_P1_C0: nxt_state = din ? ST_P2_C1 : ST_P2_C0;
                ST_P1_C1: nxt_state = ST_P2_C1;
                // bit2 gets carry only: carry out = din & carry
                ST_P2_C0: nxt_state = ST_P3_C0;
                ST_P2_C1: nxt_state = din ? ST_P3_C1 : ST_P3_C0;
                // bit3 closes the digit
                ST_P3_C0,
                ST_P3_C1: nxt_state = ST_IDLE;
                default:  nxt_state = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/e3_out_logic.sv
// Mealy output logic: the excess-3 bit and the last-bit marker, computed from
// the present state and the present input. Assumes outputs matter only while
// din_vld is high; they are forced to 0 otherwise.
module e3_out_logic
    import e3_pkg::*;
(
    input  e3_state_t cur_state,
    input  logic      din,
    input  logic      din_vld,
    output logic      dout,
    output logic      last_bit
);

    logic carry;
    logic [POS_W-1:0] pos;

    // Decode position and carry from the state.
    always_comb begin
        carry = state_carry(cur_state);
        pos   = state_pos(cur_state);
    end

    // Sum bit of din plus the constant bit of 3 plus carry.
    always_comb begin
        dout     = 1'b0;
        last_bit = 1'b0;
        if (din_vld) begin
            case (pos)
                POS_W'(0): dout = ~din;
                POS_W'(1): dout = ~(din ^ carry);
                default:   dout = din ^ carry;
            endcase
            last_bit = (pos == POS_W'(DIGIT_BITS - 1));
        end
    end

endmodule

// File: rtl/e3_range_track.sv
// Range tracker: remembers whether bit1 or bit2 of the digit was set, so that
// the last bit can flag codes above 9. Assumes pos comes from the state
// register and that a bubble (din_vld low) must leave its memory unchanged.
module e3_range_track
    import e3_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] pos,
    input  logic             din,
    input  logic             din_vld,
    output logic             bad
);

    logic mid_seen_q;

    // Collect bit1 | bit2; clear at bit0 and on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_seen_q <= 1'b0;
        end else if (din_vld) begin
            if (pos == POS_W'(0))
                mid_seen_q <= 1'b0;
            else if (pos != POS_W'(DIGIT_BITS - 1))
                mid_seen_q <= mid_seen_q | din;
        end
    end

    // Code above 9: bit3 set together with bit1 or bit2.
    always_comb begin
        bad = din_vld && (pos == POS_W'(DIGIT_BITS - 1)) && din && mid_seen_q;
    end

    // R5
    bad_needs_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad |-> (din && mid_seen_q));

    // R3
    mid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !din_vld |=> $stable(mid_seen_q));

endmodule

// File: rtl/e3_serial_conv.sv
// Top: serial BCD (least significant bit first) to excess-3 converter. It
// holds the state register and ties the next-state, output and range logic
// together. Assumes a synchronous active-low reset and one bit per valid cycle.
module e3_serial_conv
    import e3_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ser_bit,
    input  logic ser_valid,
    output logic e3_bit,
    output logic digit_last,
    output logic digit_bad
);

    e3_state_t        state_q;
    e3_state_t        state_d;
    logic             raw_bit;
    logic             raw_last;
    logic             raw_bad;
    logic [POS_W-1:0] cur_pos;

    // Position of the expected bit, shared with the range tracker.
    always_comb cur_pos = state_pos(state_q);

    // State register with synchronous reset to the start state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    e3_next_state u_next (
        .cur_state (state_q),
        .din       (ser_bit),
        .din_vld   (ser_valid),
        .nxt_state (state_d)
    );

    e3_out_logic u_out (
        .cur_state (state_q),
        .din       (ser_bit),
        .din_vld   (ser_valid),
        .dout      (raw_bit),
        .last_bit  (raw_last)
    );

    e3_range_track u_range (
        .clk     (clk),
        .rst_n   (rst_n),
        .pos     (cur_pos),
        .din     (ser_bit),
        .din_vld (ser_valid),
        .bad     (raw_bad)
    );

    // Outputs are held quiet while reset is applied.
    always_comb begin
        e3_bit     = rst_n & raw_bit;
        digit_last = rst_n & raw_last;
        digit_bad  = rst_n & raw_bad;
    end

    // R3
    bubble_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_valid |=> $stable(state_q));

    // R3
    bubble_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_valid |-> (!e3_bit && !digit_last));

    // R4
    last_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        digit_last |=> (state_q == ST_IDLE));

    // R5
    bad_only_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        digit_bad |-> digit_last);

    // R4
    legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != e3_state_t'(3'd7));

endmodule

// File: tb/sim_e3_serial_conv.sv
module sim_e3_serial_conv;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_bit = 1'b0;
    logic ser_valid = 1'b0;
    logic e3_bit, digit_last, digit_bad;

    int errors = 0;
    int checks = 0;
    // Reference model state: bits accepted so far in the current digit.
    int m_pos = 0;
    int m_val = 0;
    bit after_reset = 1'b0;

    always #2 clk = ~clk;

    e3_serial_conv u0 (
        .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .ser_valid(ser_valid),
        .e3_bit(e3_bit), .digit_last(digit_last), .digit_bad(digit_bad)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, compare mid-cycle, update the model.
    task automatic step(input bit b, input bit v);
        int full, eo, ed, eb;
        string rq;
        @(negedge clk);
        ser_bit = b;
        ser_valid = v;
        #1;
        if (!v) begin
            check("R3", "e3_bit in bubble", e3_bit, 0);
            check("R3", "digit_last in bubble", digit_last, 0);
            check("R3", "digit_bad in bubble", digit_bad, 0);
        end else begin
            full = m_val | (int'(b) << m_pos);
            eo = ((full + 3) >> m_pos) & 1;    // same-cycle Mealy bit
            ed = (m_pos == 3) ? 1 : 0;
            eb = (ed == 1 && full > 9) ? 1 : 0;
            rq = (after_reset) ? "R6" : "R2";
            check(rq, "e3_bit", e3_bit, eo);
            check("R4", "digit_last", digit_last, ed);
            check("R5", "digit_bad", digit_bad, eb);
            if (m_pos == 3) begin
                m_pos = 0;
                m_val = 0;
                after_reset = 1'b0;
            end else begin
                m_pos++;
                m_val = full;
            end
        end
        @(posedge clk);
    endtask

    task automatic reset_cycle();
        @(negedge clk);
        rst_n = 1'b0;
        ser_valid = 1'b1;
        ser_bit = 1'b1;
        #1;
        check("R1", "e3_bit in reset", e3_bit, 0);
        check("R1", "digit_last in reset", digit_last, 0);
        check("R1", "digit_bad in reset", digit_bad, 0);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        ser_valid = 1'b0;
        m_pos = 0;
        m_val = 0;
    endtask

    task automatic send_digit(input int d, input int gap_after);
        for (int k = 0; k < 4; k++) begin
            step(d[k], 1'b1);
            if (k == gap_after) begin
                step(1'b1, 1'b0);
                step(1'b0, 1'b0);
            end
        end
    endtask

    initial begin
        int lfsr;
        reset_cycle();
        // All sixteen codes back to back, no resets between digits (R2, R4, R5).
        for (int d = 0; d < 16; d++) send_digit(d, -1);
        // Every code with bubbles after each bit position (R3).
        for (int g = 0; g < 4; g++)
            for (int d = 0; d < 16; d++) send_digit(d, g);
        // Reset after 1, 2 and 3 bits of a digit, then a full digit (R6).
        for (int p = 1; p < 4; p++) begin
            for (int k = 0; k < p; k++) step(1'b1, 1'b1);
            reset_cycle();
            after_reset = 1'b1;
            send_digit(5, -1);
            after_reset = 1'b1;
            send_digit(12, 1);
        end
        // Pseudo-random bits and bubbles.
        lfsr = 32'h1ACE5;
        for (int i = 0; i < 3000; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
            step(lfsr[3], lfsr[7] | lfsr[9]);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog all-requirements actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule